// File: doc/BRIEF.md
# Banked General-Purpose Pin Controller

This block drives and samples a set of general-purpose pins arranged in banks of up to 32 pins. Software reaches it through a plain register port. Each request is one cycle of `bus_valid` carrying a write flag, a word address and 32 bits of write data. For every bank there is a direction register and an output-enable register. A pin drives its output level only while both of its bits are 1. There is also a read-only register that reports the synchronized level of each pin.

The output levels are not written through a plain register. Each bank has two write-only half-word ports, one for pins 0–15 and one for pins 16–31. In each port the upper 16 bits of the write word act as a per-bit write protect for the lower 16 data bits. Software can therefore set or clear any single pin in one write, with no read-modify-write and no race against other agents. The bank count, the pin count of each bank and a set of always-output pins in bank 0 are parameters. The default build has four banks of 32, 22, 32 and 32 pins. Pins 7 and 8 of bank 0 are fixed outputs.

Top module: `gpio_banked_top`

## Requirements
- R1: After a synchronous reset every direction, output-enable and output-data bit is 0, except the fixed-output direction bits of bank 0, which are 1. All `pin_oe` and `pin_out` bits are 0.
- R2: A write to byte address 8*b (low half-word port of bank b) updates output-data bit i of pins 0–15 to write-data bit i wherever write-data bit 16+i is 0.
- R3: A write to byte address 8*b+4 (high half-word port of bank b) updates output-data bit 16+i to write-data bit i wherever write-data bit 16+i is 0.
- R4: Wherever a protect bit (write-data bit 16+i) is 1, the corresponding output-data bit keeps its value. An all-ones protect field changes nothing.
- R5: A read of either half-word port returns 0.
- R6: Byte address 0x060+4*b reads the levels of bank b, with bit n holding pin n after a two-flop synchronizer. Pins change at one edge. A read issued at the next edge still returns the previous levels, and a read issued one edge later returns the new levels.
- R7: Byte address 0x204+0x40*b is the direction register of bank b. It can be read and written, and a 1 bit makes that pin an output.
- R8: Byte address 0x208+0x40*b is the output-enable register of bank b. It can be read and written.
- R9: `pin_oe` bit n of a bank equals direction AND output-enable for that pin. `pin_out` bit n equals the output-data bit where `pin_oe` is 1, and 0 elsewhere. Both change on the edge that completes the write.
- R10: Register bits at or above a bank's pin count read back 0, ignore writes and keep `pin_oe`/`pin_out` at 0. In bank 1 that means bits 22–31.
- R11: Direction bits 7 and 8 of bank 0 always read 1, and writing 0 to them has no effect.
- R12: `bus_rdata` is loaded on the clock edge that accepts a read and holds its value until the next read. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request strobe, one request per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the accepting edge |
| pin_in | input | NUM_BANKS*32 | Pin levels, bank b at bits 32b+31:32b |
| pin_out | output | NUM_BANKS*32 | Pin drive levels, same layout |
| pin_oe | output | NUM_BANKS*32 | Pin driver enables, same layout |

## Verification
Register writes take effect on the edge that accepts them. The bench drives each request at a falling edge and compares `pin_out`, `pin_oe` and read-back values at the following falling edge, one edge after the request. Read data is likewise compared at the falling edge just after the accepting edge. Pin levels take two edges to reach the level register. The bench therefore issues one read at the first falling edge after a pin change, where it expects the old levels, and a second read one edge later, where it expects the new levels. It also waits three edges in the level sweeps so that each pattern has settled before it is read.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

    localparam int unsigned BYTE_ADDR_W = 12;
    localparam int unsigned MAX_BANKS   = 8;
    localparam int unsigned BANK_IDX_W  = $clog2(MAX_BANKS);
    localparam int unsigned BANK_BITS   = 32;
    localparam int unsigned HALF_BITS   = 16;

    localparam logic [BYTE_ADDR_W-1:0] LEVEL_BASE = 12'h060;
    localparam logic [BYTE_ADDR_W-1:0] DIR_BASE   = 12'h204;
    localparam logic [BYTE_ADDR_W-1:0] OEN_BASE   = 12'h208;
    localparam int unsigned            CFG_STRIDE = 'h40;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_HALF_LO,
        ACC_HALF_HI,
        ACC_LEVEL,
        ACC_DIR,
        ACC_OEN
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } acc_dec_t;

    typedef struct packed {
        logic [BANK_BITS-1:0] dir;
        logic [BANK_BITS-1:0] oen;
        logic [BANK_BITS-1:0] dat;
    } bank_state_t;

    function automatic logic [BANK_BITS-1:0] pin_mask(input int unsigned n);
        if (n >= BANK_BITS) return '1;
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic acc_dec_t decode_addr(input logic [BYTE_ADDR_W-1:0] a,
                                             input int unsigned nb);
        acc_dec_t d;
        d.kind = ACC_NONE;
        d.bank = '0;
        for (int unsigned b = 0; b < MAX_BANKS; b++) begin
            if (b < nb) begin
                if (a == BYTE_ADDR_W'(8 * b)) begin
                    d.kind = ACC_HALF_LO;
                    d.bank = BANK_IDX_W'(b);
                end
                if (a == BYTE_ADDR_W'(8 * b + 4)) begin
                    d.kind = ACC_HALF_HI;
                    d.bank = BANK_IDX_W'(b);
                end
                if (a == LEVEL_BASE + BYTE_ADDR_W'(4 * b)) begin
                    d.kind = ACC_LEVEL;
                    d.bank = BANK_IDX_W'(b);
                end
                if (a == DIR_BASE + BYTE_ADDR_W'(CFG_STRIDE * b)) begin
                    d.kind = ACC_DIR;
                    d.bank = BANK_IDX_W'(b);
                end
                if (a == OEN_BASE + BYTE_ADDR_W'(CFG_STRIDE * b)) begin
                    d.kind = ACC_OEN;
                    d.bank = BANK_IDX_W'(b);
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // cycles since reset, saturating, so the delay check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (sync_out == $past(raw_in, 2)));  // R6

endmodule

// File: rtl/gpio_bank_unit.sv
module gpio_bank_unit
    import gpio_banked_pkg::*;
#(
    parameter int unsigned          PINS     = 32,
    parameter logic [BANK_BITS-1:0] FIXED_OUT = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic                 wr_dir,
    input  logic                 wr_oen,
    input  logic [31:0]          wdata,
    input  logic [BANK_BITS-1:0] sync_in,
    output logic [BANK_BITS-1:0] dir_rd,
    output logic [BANK_BITS-1:0] oen_rd,
    output logic [BANK_BITS-1:0] level_rd,
    output logic [BANK_BITS-1:0] drv_out,
    output logic [BANK_BITS-1:0] drv_oe
);
    localparam logic [BANK_BITS-1:0] VALID = pin_mask(PINS);
    localparam logic [BANK_BITS-1:0] RSV   = FIXED_OUT & VALID;

    bank_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < HALF_BITS; i++) begin
            if (wr_lo && !wdata[HALF_BITS + i]) st_d.dat[i]             = wdata[i];
            if (wr_hi && !wdata[HALF_BITS + i]) st_d.dat[HALF_BITS + i] = wdata[i];
        end
        if (wr_dir) st_d.dir = wdata | RSV;
        if (wr_oen) st_d.oen = wdata;
        st_d.dir = st_d.dir & VALID;
        st_d.oen = st_d.oen & VALID;
        st_d.dat = st_d.dat & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dir <= RSV;
            st_q.oen <= '0;
            st_q.dat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_rd   = st_q.dir;
    assign oen_rd   = st_q.oen;
    assign level_rd = sync_in & VALID;
    assign drv_oe   = st_q.dir & st_q.oen;
    assign drv_out  = st_q.dat & drv_oe;

    AST_FIXED_DIR: assert property (@(posedge clk) disable iff (rst)
        (dir_rd & RSV) == RSV);  // R11

    AST_ABOVE_PINS: assert property (@(posedge clk) disable iff (rst)
        ((st_q.dir | st_q.oen | st_q.dat) & ~VALID) == '0);  // R10

    AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi && wdata[31:16] == 16'hFFFF) |=> $stable(st_q.dat[15:0]));  // R4

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!wr_dir && !wr_oen) |=> $stable(drv_oe));  // R9

endmodule

// File: rtl/gpio_banked_top.sv
module gpio_banked_top
    import gpio_banked_pkg::*;
#(
    parameter int unsigned                NUM_BANKS   = 4,
    parameter logic [NUM_BANKS*6-1:0]     BANK_PINS   = {6'd32, 6'd32, 6'd22, 6'd32},
    parameter logic [BANK_BITS-1:0]       B0_FIXED_OUT = 32'h0000_0180,
    localparam int unsigned               WORD_ADDR_W = BYTE_ADDR_W - 2,
    localparam int unsigned               PIN_W       = NUM_BANKS * BANK_BITS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [WORD_ADDR_W-1:0] bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [PIN_W-1:0]       pin_in,
    output logic [PIN_W-1:0]       pin_out,
    output logic [PIN_W-1:0]       pin_oe
);
    acc_dec_t dec;
    logic     wr_req;
    logic     rd_req;

    assign dec    = decode_addr({bus_addr, 2'b00}, NUM_BANKS);
    assign wr_req = bus_valid && bus_write;
    assign rd_req = bus_valid && !bus_write;

    logic [PIN_W-1:0] pin_sync;

    gpio_in_sync #(.WIDTH(PIN_W)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    logic [NUM_BANKS-1:0][BANK_BITS-1:0] dir_v, oen_v, lvl_v;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (dec.bank == BANK_IDX_W'(b));

        gpio_bank_unit #(
            .PINS      (int'(BANK_PINS[6*b +: 6])),
            .FIXED_OUT ((b == 0) ? B0_FIXED_OUT : '0)
        ) bank_i (
            .clk      (clk),
            .rst      (rst),
            .wr_lo    (wr_req && hit && dec.kind == ACC_HALF_LO),
            .wr_hi    (wr_req && hit && dec.kind == ACC_HALF_HI),
            .wr_dir   (wr_req && hit && dec.kind == ACC_DIR),
            .wr_oen   (wr_req && hit && dec.kind == ACC_OEN),
            .wdata    (bus_wdata),
            .sync_in  (pin_sync[BANK_BITS*b +: BANK_BITS]),
            .dir_rd   (dir_v[b]),
            .oen_rd   (oen_v[b]),
            .level_rd (lvl_v[b]),
            .drv_out  (pin_out[BANK_BITS*b +: BANK_BITS]),
            .drv_oe   (pin_oe[BANK_BITS*b +: BANK_BITS])
        );
    end

    logic [31:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.bank == BANK_IDX_W'(b)) begin
                unique case (dec.kind)
                    ACC_LEVEL: rd_word = lvl_v[b];
                    ACC_DIR:   rd_word = dir_v[b];
                    ACC_OEN:   rd_word = oen_v[b];
                    default:   rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_word;
    end

    AST_HALF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (dec.kind == ACC_HALF_LO || dec.kind == ACC_HALF_HI)) |=> (bus_rdata == '0));  // R5

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(bus_rdata));  // R12

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && dec.kind == ACC_NONE) |=> (bus_rdata == '0));  // R12

endmodule

// File: tb/gpio_banked_top_tb_top.sv
module gpio_banked_top_tb_top;

    localparam int NB = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [9:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out;
    logic [127:0] pin_oe;

    always #2 clk = ~clk;

    gpio_banked_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int          npins [NB] = '{32, 22, 32, 32};
    logic [31:0] vmask [NB];
    logic [31:0] m_dir [NB];
    logic [31:0] m_oen [NB];
    logic [31:0] m_dat [NB];
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] ba, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = ba[11:2]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] ba, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = ba[11:2];
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_pins(input string tag, input int b);
        logic [31:0] eoe;
        eoe = m_dir[b] & m_oen[b] & vmask[b];
        chk({tag, " pin_oe"},  pin_oe[32*b +: 32],  eoe);
        chk({tag, " pin_out"}, pin_out[32*b +: 32], m_dat[b] & eoe);
    endtask

    function automatic void model_half(input int b, input bit hi, input logic [31:0] w);
        for (int i = 0; i < 16; i++)
            if (!w[16+i]) m_dat[b][(hi ? 16 : 0) + i] = w[i];
        m_dat[b] &= vmask[b];
    endfunction

    initial begin
        logic [31:0] r;
        logic [31:0] w;
        logic [31:0] old_lvl;
        for (int b = 0; b < NB; b++) begin
            vmask[b] = (npins[b] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << npins[b]) - 32'd1);
            m_dir[b] = (b == 0) ? 32'h0000_0180 : 32'h0;
            m_oen[b] = '0;
            m_dat[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R11: reset state
        chk("R1 pin_oe all", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64] | pin_oe[127:96], '0);
        chk("R1 pin_out all", pin_out[31:0] | pin_out[63:32] | pin_out[95:64] | pin_out[127:96], '0);
        for (int b = 0; b < NB; b++) begin
            bus_rd(12'h204 + 12'(64 * b), r); chk("R1 R11 dir reset", r, m_dir[b]);
            bus_rd(12'h208 + 12'(64 * b), r); chk("R1 oen reset", r, '0);
        end

        // R7 R8 R10: config registers, full write and readback
        for (int b = 0; b < NB; b++) begin
            bus_wr(12'h204 + 12'(64 * b), 32'hFFFF_FFFF); m_dir[b] = vmask[b];
            bus_wr(12'h208 + 12'(64 * b), 32'hFFFF_FFFF); m_oen[b] = vmask[b];
            bus_rd(12'h204 + 12'(64 * b), r); chk("R7 R10 dir readback", r, vmask[b]);
            bus_rd(12'h208 + 12'(64 * b), r); chk("R8 R10 oen readback", r, vmask[b]);
            chk_pins("R9 all enabled", b);
        end

        // R2 R3 R4: masked half-word writes with varied protect patterns
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 12; k++) begin
                w = next_rand();
                bus_wr(12'(8 * b), w);     model_half(b, 1'b0, w); chk_pins("R2 low half", b);
                w = next_rand();
                bus_wr(12'(8 * b + 4), w); model_half(b, 1'b1, w); chk_pins("R3 high half", b);
            end
            bus_wr(12'(8 * b), 32'h0000_FFFF);     model_half(b, 1'b0, 32'h0000_FFFF); chk_pins("R2 set all low", b);
            bus_wr(12'(8 * b + 4), 32'h0000_0000); model_half(b, 1'b1, 32'h0); chk_pins("R3 clear all high", b);
            bus_wr(12'(8 * b), 32'hFFFF_0000);     chk_pins("R4 full protect low", b);
            bus_wr(12'(8 * b + 4), 32'hFFFF_FFFF); chk_pins("R4 full protect high", b);
            bus_wr(12'(8 * b + 4), 32'hFFFE_0001); model_half(b, 1'b1, 32'hFFFE_0001); chk_pins("R4 single bit set", b);
            bus_rd(12'(8 * b), r);     chk("R5 low half read", r, '0);
            bus_rd(12'(8 * b + 4), r); chk("R5 high half read", r, '0);
        end

        // R11: fixed output bits ignore a 0 write
        bus_wr(12'h204, 32'h0); m_dir[0] = 32'h0000_0180;
        bus_rd(12'h204, r); chk("R11 fixed dir bits", r, 32'h0000_0180);
        chk_pins("R11 R9 bank0 after dir clear", 0);

        // R9 R10: mixed direction / enable patterns
        for (int b = 1; b < NB; b++) begin
            bus_wr(12'h204 + 12'(64 * b), 32'hA5A5_F00F); m_dir[b] = 32'hA5A5_F00F & vmask[b];
            chk_pins("R9 dir pattern", b);
            bus_wr(12'h208 + 12'(64 * b), 32'h0FF0_FFFF); m_oen[b] = 32'h0FF0_FFFF & vmask[b];
            chk_pins("R9 oen pattern", b);
            bus_rd(12'h204 + 12'(64 * b), r); chk("R10 dir masked", r, m_dir[b]);
        end
        // R9: output data written while disabled appears when enabled
        bus_wr(12'h208 + 12'(64 * 2), 32'h0); m_oen[2] = 32'h0;
        bus_wr(12'(16), 32'h0000_5A5A); model_half(2, 1'b0, 32'h0000_5A5A);
        chk_pins("R9 disabled drives zero", 2);
        bus_wr(12'h208 + 12'(64 * 2), 32'hFFFF_FFFF); m_oen[2] = 32'hFFFF_FFFF;
        chk_pins("R9 enable reveals data", 2);

        // R6 R10: pin level sweep
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                pin_in[32*b +: 32] = (k == 0) ? 32'hFFFF_FFFF : next_rand();
                repeat (3) @(negedge clk);
                bus_rd(12'h060 + 12'(4 * b), r);
                chk("R6 R10 level", r, pin_in[32*b +: 32] & vmask[b]);
            end
        end

        // R6: synchronizer latency
        @(negedge clk);
        pin_in[31:0] = 32'h1111_0000;
        repeat (3) @(negedge clk);
        old_lvl = 32'h1111_0000;
        pin_in[31:0] = 32'hC0DE_0042;
        bus_rd(12'h060, r); chk("R6 early read old level", r, old_lvl);
        bus_rd(12'h060, r); chk("R6 later read new level", r, 32'hC0DE_0042);

        // R12: unmapped read and read-data hold
        bus_rd(12'h100, r); chk("R12 unmapped read", r, '0);
        bus_rd(12'h208 + 12'(64 * 3), r); chk("R12 oen read", r, m_oen[3]);
        bus_wr(12'h204, 32'hFFFF_FFFF); m_dir[0] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R12 rdata held", bus_rdata, m_oen[3]);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule